// File: doc/BRIEF.md
# Expansion-Window Register Decoder with Mode Latch

This block sits on an 8-bit host bus behind a 256-byte expansion I/O window. While the window select is low, it decodes the bottom sixteen bytes of the window into eight active-low function strobes. Each strobe comes as a separate read line and write line. Decoding starts at address bit A1, so every strobe answers to an even/odd address pair. Addresses above offset 0x0F inside the window produce no strobe at all. The strobes feed the peripheral devices on the cartridge. Those devices are not part of this block.

The block also holds a write-only mode latch at offset 0x0A. It captures the data bus on the falling edge of the host's phase-2 clock during a write cycle. The latched bits are as follows:
- An enable for the outgoing clock.
- A disable for the incoming clock.
- A gate on the interrupt request toward the host.
- The drum trigger mode.

The latch bits have mixed polarities. The block also drives the enable and direction of the cartridge's data bus transceiver.

A system clock with a synchronous active-high reset samples the phase-2 level. The falling edge of phase-2 is detected in that clock domain.

Top module: `cart_io_decode`

## Requirements
- R1: While `io_sel_n` is high, every line of `rd_sel_n` and `wr_sel_n` is high.
- R2: With `io_sel_n` low, an address with any bit above bit 3 set (window offset 0x10 to 0xFF) drives no strobe low.
- R3: With `io_sel_n` low and offset 0x00–0x0F, the strobe index is address bits [3:1], so offsets 2k and 2k+1 select line k. When `rw` is 1 (read), `rd_sel_n[k]` goes low. When `rw` is 0 (write), `wr_sel_n[k]` goes low.
- R4: At most one of the sixteen strobe lines is low at any time.
- R5: The mode latch loads `data_in` on the first system clock edge at which `phi2` is seen low after being high, provided that a write (`rw`=0) to offset 0x0A or 0x0B is presented with `io_sel_n` low. Reads, other offsets and an inactive window leave it unchanged. A write held with `phi2` high does not load it.
- R6: Latch bit 0 is the clock-output control. The value 1 sets `clk_out_en`=1, and the value 0 disables the clock output.
- R7: Latch bit 1 is the clock-input control with the opposite sense. The value 1 disables the clock input (`clk_in_en`=0), and the value 0 enables it.
- R8: Latch bit 2 gates interrupts. With bit 2 = 0, `host_irq_n` is held high. With bit 2 = 1, `host_irq_n` follows `irq_req_n`.
- R9: Latch bit 3 selects the drum trigger mode. The value 0 means latched (`drum_pulse_mode`=0) and the value 1 means pulsed (`drum_pulse_mode`=1). Data bits 7..4 have no effect on any output.
- R10: Reset clears the latch to 0x00. This leaves the clock output disabled, the clock input enabled, `host_irq_n` high and the drum mode latched.
- R11: `xcvr_en_n` is low exactly while `io_sel_n` is low. `xcvr_to_host` is 1 (toward host) only while the window is active and `rw` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel_n | input | 1 | Expansion window select, active low |
| rw | input | 1 | Host read (1) / write (0) |
| phi2 | input | 1 | Host phase-2 clock level |
| addr | input | 7 | Host address bits A7..A1 (A0 not used) |
| data_in | input | 8 | Host data bus into the cartridge |
| irq_req_n | input | 1 | Interrupt request from cartridge devices, active low |
| rd_sel_n | output | 8 | Read strobes, active low, one per address pair |
| wr_sel_n | output | 8 | Write strobes, active low, one per address pair |
| clk_out_en | output | 1 | Clock output enable |
| clk_in_en | output | 1 | Clock input enable |
| drum_pulse_mode | output | 1 | Drum trigger mode: 0 latched, 1 pulsed |
| host_irq_n | output | 1 | Gated interrupt request to the host, active low |
| xcvr_en_n | output | 1 | Data transceiver enable, active low |
| xcvr_to_host | output | 1 | Transceiver direction, 1 = drive toward host |

## Verification
The bench builds the block with its defaults: an 8-bit window offset, three decoded slot bits (eight strobe pairs), and the mode latch in slot 5. With these values every strobe, both members of each address pair, and offsets just past 0x0F and at the window's top are reachable from a short table. The 4-bit control field and the ignored upper data nibble can be reached with single writes. Directed writes then exercise the phase-2 fall timing, rejected writes (read, wrong offset, inactive window) and reset in the middle of a run.

// File: rtl/cart_io_pkg.sv
package cart_io_pkg;

    localparam int DATA_W = 8;

    // Mode latch layout, bit 3 down to bit 0
    typedef struct packed {
        logic drum_pulse;   // bit 3: 1 = pulsed, 0 = latched
        logic irq_pass;     // bit 2: 0 = interrupt blocked
        logic clk_in_off;   // bit 1: 1 = clock input disabled
        logic clk_out_on;   // bit 0: 0 = clock output disabled
    } mode_t;

    localparam mode_t MODE_RESET = '0;

    typedef enum logic {
        DIR_TO_CART = 1'b0,
        DIR_TO_HOST = 1'b1
    } xdir_e;

    // Only the low nibble of the bus carries mode bits
    function automatic mode_t mode_from_bus(input logic [DATA_W-1:0] d);
        mode_t m;
        m = mode_t'(d[3:0]);
        return m;
    endfunction

    function automatic logic slot_in_range(input logic [6:0] hi_bits, input int slot_bits);
        logic hit;
        hit = 1'b1;
        for (int i = 0; i < 7; i++) begin
            if (i >= slot_bits && hi_bits[i]) hit = 1'b0;
        end
        return hit;
    endfunction

endpackage

// File: rtl/cart_addr_decode.sv
module cart_addr_decode
    import cart_io_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SLOT_BITS = 3,
    parameter int CTRL_SLOT = 5,
    localparam int SEL_N    = 1 << SLOT_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_sel_n,
    input  logic              rw,
    input  logic [ADDR_W-1:1] addr,
    output logic [SEL_N-1:0]  rd_sel_n,
    output logic [SEL_N-1:0]  wr_sel_n,
    output logic              ctrl_wr_hit
);
    localparam int HI_W = ADDR_W - 1;

    logic                 in_range;
    logic                 active;
    logic [SLOT_BITS-1:0] slot;
    logic [HI_W-1:0]      hi_view;

    assign hi_view  = addr[ADDR_W-1:1];
    assign slot     = addr[SLOT_BITS:1];
    assign in_range = slot_in_range(7'(hi_view), SLOT_BITS);
    assign active   = !io_sel_n && in_range;

    for (genvar k = 0; k < SEL_N; k++) begin : g_strobe
        logic hit;
        assign hit         = active && (slot == SLOT_BITS'(k));
        assign rd_sel_n[k] = !(hit && rw);
        assign wr_sel_n[k] = !(hit && !rw);
    end

    assign ctrl_wr_hit = !wr_sel_n[CTRL_SLOT];

    p_idle_window_r1: assert property (@(posedge clk) disable iff (rst)
        io_sel_n |-> (&rd_sel_n && &wr_sel_n));

    p_above_range_r2: assert property (@(posedge clk) disable iff (rst)
        (addr[ADDR_W-1:SLOT_BITS+1] != '0) |-> (&rd_sel_n && &wr_sel_n));

    p_single_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~{rd_sel_n, wr_sel_n}));

    p_rw_split_r3: assert property (@(posedge clk) disable iff (rst)
        rw |-> &wr_sel_n);

endmodule

// File: rtl/cart_mode_latch.sv
module cart_mode_latch
    import cart_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              phi2,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] data,
    output mode_t             mode
);
    logic  phi2_q;
    logic  capture;
    mode_t mode_q;

    assign capture = wr_hit && phi2_q && !phi2;

    always_ff @(posedge clk) begin
        if (rst) begin
            phi2_q <= 1'b0;
            mode_q <= MODE_RESET;
        end else begin
            phi2_q <= phi2;
            if (capture) mode_q <= mode_from_bus(data);
        end
    end

    assign mode = mode_q;

    p_hold_without_fall_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_hit && phi2_q && !phi2) |=> $stable(mode_q));

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (mode_q == MODE_RESET));

endmodule

// File: rtl/cart_bus_buffer.sv
module cart_bus_buffer
    import cart_io_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic io_sel_n,
    input  logic rw,
    output logic xcvr_en_n,
    output logic xcvr_to_host
);
    xdir_e dir;

    assign dir          = (!io_sel_n && rw) ? DIR_TO_HOST : DIR_TO_CART;
    assign xcvr_en_n    = io_sel_n;
    assign xcvr_to_host = (dir == DIR_TO_HOST);

    p_xcvr_idle_r11: assert property (@(posedge clk) disable iff (rst)
        io_sel_n |-> (xcvr_en_n && !xcvr_to_host));

endmodule

// File: rtl/cart_io_decode.sv
module cart_io_decode
    import cart_io_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SLOT_BITS = 3,
    parameter int CTRL_SLOT = 5,
    localparam int SEL_N    = 1 << SLOT_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_sel_n,
    input  logic              rw,
    input  logic              phi2,
    input  logic [ADDR_W-1:1] addr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              irq_req_n,
    output logic [SEL_N-1:0]  rd_sel_n,
    output logic [SEL_N-1:0]  wr_sel_n,
    output logic              clk_out_en,
    output logic              clk_in_en,
    output logic              drum_pulse_mode,
    output logic              host_irq_n,
    output logic              xcvr_en_n,
    output logic              xcvr_to_host
);
    logic  ctrl_wr_hit;
    mode_t mode;

    cart_addr_decode #(
        .ADDR_W   (ADDR_W),
        .SLOT_BITS(SLOT_BITS),
        .CTRL_SLOT(CTRL_SLOT)
    ) u_decode (
        .clk        (clk),
        .rst        (rst),
        .io_sel_n   (io_sel_n),
        .rw         (rw),
        .addr       (addr),
        .rd_sel_n   (rd_sel_n),
        .wr_sel_n   (wr_sel_n),
        .ctrl_wr_hit(ctrl_wr_hit)
    );

    cart_mode_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .phi2  (phi2),
        .wr_hit(ctrl_wr_hit),
        .data  (data_in),
        .mode  (mode)
    );

    cart_bus_buffer u_buf (
        .clk         (clk),
        .rst         (rst),
        .io_sel_n    (io_sel_n),
        .rw          (rw),
        .xcvr_en_n   (xcvr_en_n),
        .xcvr_to_host(xcvr_to_host)
    );

    assign clk_out_en      = mode.clk_out_on;
    assign clk_in_en       = !mode.clk_in_off;
    assign drum_pulse_mode = mode.drum_pulse;
    assign host_irq_n      = irq_req_n || !mode.irq_pass;

    p_irq_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        (!u_latch.mode_q.irq_pass) |-> host_irq_n);

    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        irq_req_n |-> host_irq_n);

endmodule

// File: tb/cart_io_decode_bench.sv
module cart_io_decode_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_sel_n = 1'b1;
    logic       rw = 1'b1;
    logic       phi2 = 1'b0;
    logic [7:0] a8 = 8'h00;
    logic [7:0] data_in = 8'h00;
    logic       irq_req_n = 1'b1;
    logic [7:0] rd_sel_n, wr_sel_n;
    logic       clk_out_en, clk_in_en, drum_pulse_mode, host_irq_n;
    logic       xcvr_en_n, xcvr_to_host;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cart_io_decode u_cart_io_decode (
        .clk(clk), .rst(rst), .io_sel_n(io_sel_n), .rw(rw), .phi2(phi2),
        .addr(a8[7:1]), .data_in(data_in), .irq_req_n(irq_req_n),
        .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .clk_out_en(clk_out_en), .clk_in_en(clk_in_en),
        .drum_pulse_mode(drum_pulse_mode), .host_irq_n(host_irq_n),
        .xcvr_en_n(xcvr_en_n), .xcvr_to_host(xcvr_to_host)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // {clk_out_en, clk_in_en, irq_pass_seen, drum}
    function automatic logic [3:0] mode_obs();
        return {clk_out_en, clk_in_en, ~host_irq_n, drum_pulse_mode};
    endfunction

    task automatic check_mode(input logic [3:0] exp, input string tag);
        irq_req_n = 1'b0;
        #1;
        check(mode_obs() == exp, tag, 32'(mode_obs()), 32'(exp));
        irq_req_n = 1'b1;
        #1;
        check(host_irq_n == 1'b1, "R8 idle irq", 32'(host_irq_n), 32'd1);
    endtask

    // bus cycle: phase-2 high for one clock, then falls
    task automatic bus_write(input logic sel_n, input logic rwv, input logic [7:0] ad, input logic [7:0] d);
        @(negedge clk);
        io_sel_n = sel_n; rw = rwv; a8 = ad; data_in = d; phi2 = 1'b1;
        @(negedge clk);
        phi2 = 1'b0;
        @(negedge clk);
        io_sel_n = 1'b1; rw = 1'b1;
        @(negedge clk);
    endtask

    // {io_sel_n, rw, addr[7:0], exp_rd[7:0], exp_wr[7:0]}
    localparam logic [25:0] VEC [14] = '{
        {1'b0, 1'b1, 8'h00, 8'hFE, 8'hFF},
        {1'b0, 1'b1, 8'h01, 8'hFE, 8'hFF},
        {1'b0, 1'b0, 8'h02, 8'hFF, 8'hFD},
        {1'b0, 1'b0, 8'h03, 8'hFF, 8'hFD},
        {1'b0, 1'b1, 8'h07, 8'hF7, 8'hFF},
        {1'b0, 1'b1, 8'h08, 8'hEF, 8'hFF},
        {1'b0, 1'b0, 8'h0A, 8'hFF, 8'hDF},
        {1'b0, 1'b1, 8'h0E, 8'h7F, 8'hFF},
        {1'b0, 1'b0, 8'h0F, 8'hFF, 8'h7F},
        {1'b0, 1'b1, 8'h10, 8'hFF, 8'hFF},
        {1'b0, 1'b0, 8'hFF, 8'hFF, 8'hFF},
        {1'b0, 1'b1, 8'h80, 8'hFF, 8'hFF},
        {1'b1, 1'b1, 8'h00, 8'hFF, 8'hFF},
        {1'b1, 1'b0, 8'h0A, 8'hFF, 8'hFF}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state, irq blocked even with a pending request
        check_mode(4'b0100, "R10 reset mode");
        check(xcvr_en_n == 1'b1, "R11 idle enable", 32'(xcvr_en_n), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check_mode(4'b0100, "R10 after release");

        // R1 R2 R3 R4 R11: table walk
        foreach (VEC[i]) begin
            io_sel_n = VEC[i][25]; rw = VEC[i][24]; a8 = VEC[i][23:16];
            @(negedge clk);
            check(rd_sel_n == VEC[i][15:8], "R3/R1/R2 read strobes", 32'(rd_sel_n), 32'(VEC[i][15:8]));
            check(wr_sel_n == VEC[i][7:0], "R3/R1/R2 write strobes", 32'(wr_sel_n), 32'(VEC[i][7:0]));
            check($countones(~{rd_sel_n, wr_sel_n}) <= 1, "R4 single strobe",
                  32'($countones(~{rd_sel_n, wr_sel_n})), 32'd1);
            check(xcvr_en_n == VEC[i][25], "R11 enable", 32'(xcvr_en_n), 32'(VEC[i][25]));
            check(xcvr_to_host == (!VEC[i][25] && VEC[i][24]), "R11 direction",
                  32'(xcvr_to_host), 32'(!VEC[i][25] && VEC[i][24]));
        end
        io_sel_n = 1'b1; rw = 1'b1;

        // R5: no load while phase-2 stays high
        @(negedge clk);
        io_sel_n = 1'b0; rw = 1'b0; a8 = 8'h0A; data_in = 8'h0F; phi2 = 1'b1;
        repeat (3) @(negedge clk);
        check_mode(4'b0100, "R5 phi2 high no load");
        phi2 = 1'b0;
        @(negedge clk);
        io_sel_n = 1'b1; rw = 1'b1;
        // R6 R7 R8 R9: all mode bits set
        check_mode(4'b1011, "R6 R7 R8 R9 load 0x0F");

        // R5: read, wrong offset, idle window do not load
        bus_write(1'b0, 1'b1, 8'h0A, 8'h00);
        check_mode(4'b1011, "R5 read ignored");
        bus_write(1'b0, 1'b0, 8'h0C, 8'h00);
        check_mode(4'b1011, "R5 other offset ignored");
        bus_write(1'b1, 1'b0, 8'h0A, 8'h00);
        check_mode(4'b1011, "R5 idle window ignored");
        bus_write(1'b0, 1'b0, 8'h1A, 8'h00);
        check_mode(4'b1011, "R5 R2 above range ignored");

        // R9: upper nibble ignored; odd member of pair; R6 R8 set, R7 enabled
        bus_write(1'b0, 1'b0, 8'h0B, 8'hF5);
        check_mode(4'b1110, "R9 upper nibble ignored 0xF5");
        bus_write(1'b0, 1'b0, 8'h0A, 8'h02);
        check_mode(4'b0000, "R7 clk in disabled R6 R8 off");
        bus_write(1'b0, 1'b0, 8'h0A, 8'h08);
        check_mode(4'b0101, "R9 pulsed mode");

        // R10: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_mode(4'b0100, "R10 mid-run reset");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule